// File: doc/BRIEF.md
# Receive Byte-Count and Bus-Hold Controller

This block runs the receive side of a bus master's read. Software loads a byte count and starts the read. An abstract byte engine then offers each received byte over a valid/ready handshake. For every byte the block accepts, it returns an acknowledge decision. It answers ACK while more bytes are expected and NACK on the byte that takes the count to zero. Accepted bytes go into a small receive FIFO, which software drains through a read strobe. The block raises single-cycle events for reaching the data threshold, for ending the counted read, and for FIFO overflow and underflow.

When the FIFO is full, a software hold input decides what happens to the next byte. With hold set, the block stretches the acknowledge phase by keeping ready low until a read frees a slot. With hold clear, the byte is still answered but its data is dropped. The same hold input keeps the bus claimed after the count runs out, so the engine can follow with a repeated start instead of a stop. Software may reload the count at any time, and the new value governs the next acknowledge decision.

Top module: `rx_hold_ctrl`

## Requirements
- R1: After reset, busy_o, byte_ready_o, rx_valid_o and every event output are 0, and fill_o and size_o are 0.
- R2: Accepted bytes leave the FIFO in arrival order. rd_data_o shows the oldest byte whenever rx_valid_o is 1. rx_valid_o is 1 exactly when fill_o is nonzero.
- R3: A write on size_load_i sets size_o to size_val_i at the next clock edge. Each accepted byte lowers size_o by one.
- R4: byte_ack_o is 1 (ACK) when the byte is accepted with size_o greater than 1. It is 0 (NACK) when size_o equals 1, whatever the state of hold_i.
- R5: One cycle after size_o reaches 0 during a read, comp_evt_o pulses for one cycle. busy_o then falls if hold_i is 0. If hold_i is 1, busy_o stays 1 until hold_i returns to 0.
- R6: data_evt_o pulses for one cycle after a byte is stored that brings fill_o from DEPTH-3 to DEPTH-2, with no read in the same cycle.
- R7: While the FIFO is full and hold_i is 1, byte_ready_o is 0. It returns to 1 in the cycle after a FIFO read.
- R8: A byte accepted with a full FIFO and hold_i at 0 is acknowledged per R4 but not stored, and ovf_evt_o pulses in the next cycle.
- R9: A read strobe on an empty FIFO gives rd_data_o = 0 and pulses unf_evt_o in the next cycle.
- R10: A reload during a read replaces the remaining count before the next byte's decision. Reloading to 1 makes the next byte NACK and ends the read.
- R11: fifo_clr_i empties the FIFO at the next edge, so fill_o becomes 0 and rx_valid_o becomes 0.
- R12: Outside an active read, or once size_o is 0, byte_ready_o is 0 and offered bytes do not enter the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a read (address write) |
| size_load_i | input | 1 | Load the byte count |
| size_val_i | input | SIZE_W | Count value to load |
| hold_i | input | 1 | Software bus-hold control |
| fifo_clr_i | input | 1 | Empty the receive FIFO |
| byte_valid_i | input | 1 | Engine offers a received byte |
| byte_data_i | input | DATA_W | Offered byte |
| byte_ready_o | output | 1 | Byte accepted and acknowledge decision valid |
| byte_ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rd_en_i | input | 1 | FIFO read strobe |
| rd_data_o | output | DATA_W | Oldest FIFO byte, 0 when empty |
| rx_valid_o | output | 1 | Receive data valid |
| fill_o | output | CNT_W | FIFO occupancy |
| size_o | output | SIZE_W | Remaining byte count |
| busy_o | output | 1 | Bus claimed by this read |
| data_evt_o | output | 1 | Threshold reached event |
| comp_evt_o | output | 1 | Counted read finished event |
| ovf_evt_o | output | 1 | Receive overflow event |
| unf_evt_o | output | 1 | Receive underflow event |

## Verification
The bench builds the block with DEPTH = 4, an 8-bit count and 8-bit data. At that depth the data threshold falls at two bytes, and a full FIFO is only four bytes away. This lets the bench sweep every count from 1 to the depth and reach overflow, stretching and held-bus completion within a few cycles each. It also covers reloads during a read, clears and empty reads. It predicts stored data with a queue model and derives acknowledge values, counts and event cycles arithmetically from the loaded count.

// File: rtl/rxhc_pkg.sv
package rxhc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HELD = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxhc_fifo.sv
module rxhc_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  fill_q, fill_d;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    fill_d = fill_q;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
      fill_d = '0;
    end else begin
      if (push_i) wptr_d = step(wptr_q);
      if (pop_i)  rptr_d = step(rptr_q);
      if (push_i && !pop_i)      fill_d = fill_q + 1'b1;
      else if (!push_i && pop_i) fill_d = fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i) mem[wptr_q] <= data_i;
  end

  assign head_o  = mem[rptr_q];
  assign fill_o  = fill_q;
  assign empty_o = (fill_q == '0);
  assign full_o  = (fill_q == FULL_CNT);
endmodule

// File: rtl/rxhc_size_ctrl.sv
module rxhc_size_ctrl
  import rxhc_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [SIZE_W-1:0] load_val_i,
  input  logic              take_i,
  input  logic              hold_i,
  output logic [SIZE_W-1:0] cnt_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o
);
  rx_state_e         state_q, state_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic              done_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                    cnt_d = load_val_i;
    else if (take_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (cnt_q == '0) begin
          done_d  = 1'b1;
          state_d = hold_i ? ST_HELD : ST_IDLE;
        end
      end
      ST_HELD: begin
        if (start_i)     state_d = ST_RUN;
        else if (!hold_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = (state_q == ST_RUN);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_d;
endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              size_load_i,
  input  logic [SIZE_W-1:0] size_val_i,
  input  logic              hold_i,
  input  logic              fifo_clr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  output logic              byte_ack_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_valid_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              busy_o,
  output logic              data_evt_o,
  output logic              comp_evt_o,
  output logic              ovf_evt_o,
  output logic              unf_evt_o
);
  localparam logic [CNT_W-1:0] PRE_THR = CNT_W'(DEPTH - 3);

  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  fill;
  logic              empty, full;
  logic [SIZE_W-1:0] cnt;
  logic              run, busy, done;
  logic              accept, push, pop;
  logic              data_d, ovf_d, unf_d;
  logic              data_q, comp_q, ovf_q, unf_q;

  assign byte_ready_o = run && (cnt != '0) && !(full && hold_i);
  assign accept       = byte_valid_i && byte_ready_o;
  assign push         = accept && !full && !fifo_clr_i;
  assign pop          = rd_en_i && !empty && !fifo_clr_i;
  assign byte_ack_o   = (cnt > SIZE_W'(1));

  rxhc_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr_i),
    .push_i(push), .data_i(byte_data_i), .pop_i(pop),
    .head_o(head), .fill_o(fill), .empty_o(empty), .full_o(full)
  );

  rxhc_size_ctrl #(.SIZE_W(SIZE_W)) size_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_i(size_load_i), .load_val_i(size_val_i),
    .take_i(accept), .hold_i(hold_i),
    .cnt_o(cnt), .run_o(run), .busy_o(busy), .done_o(done)
  );

  always_comb begin
    data_d = push && !pop && (fill == PRE_THR);
    ovf_d  = accept && full;
    unf_d  = rd_en_i && empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      comp_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      comp_q <= done;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign rd_data_o  = empty ? '0 : head;
  assign rx_valid_o = !empty;
  assign fill_o     = fill;
  assign size_o     = cnt;
  assign busy_o     = busy;
  assign data_evt_o = data_q;
  assign comp_evt_o = comp_q;
  assign ovf_evt_o  = ovf_q;
  assign unf_evt_o  = unf_q;
endmodule

// File: rtl/rx_hold_ctrl_chk.sv
module rx_hold_ctrl_chk #(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid_i,
  input logic              byte_ready_o,
  input logic              byte_ack_o,
  input logic              hold_i,
  input logic              size_load_i,
  input logic              rd_en_i,
  input logic              rx_valid_o,
  input logic [CNT_W-1:0]  fill_o,
  input logic [SIZE_W-1:0] size_o,
  input logic              busy_o,
  input logic              unf_evt_o
);
  assert_valid_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o == (fill_o != '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && byte_ready_o && !size_load_i) |=> size_o == $past(size_o) - 1'b1);

  assert_last_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready_o && size_o == SIZE_W'(1)) |-> !byte_ack_o);

  assert_stretch_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && hold_i && fill_o == CNT_W'(DEPTH)) |-> !byte_ready_o);

  assert_underflow_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rx_valid_o) |=> unf_evt_o);

  assert_idle_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o || size_o == '0) |-> !byte_ready_o);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= CNT_W'(DEPTH));
endmodule

bind rx_hold_ctrl rx_hold_ctrl_chk #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i),
  .byte_ready_o(byte_ready_o), .byte_ack_o(byte_ack_o), .hold_i(hold_i),
  .size_load_i(size_load_i), .rd_en_i(rd_en_i), .rx_valid_o(rx_valid_o),
  .fill_o(fill_o), .size_o(size_o), .busy_o(busy_o), .unf_evt_o(unf_evt_o)
);

// File: tb/rx_hold_ctrl_tb_top.sv
module rx_hold_ctrl_tb_top;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int SW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TH    = DEPTH - 2;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, size_load_i, hold_i, fifo_clr_i, byte_valid_i, rd_en_i;
  logic [SW-1:0] size_val_i;
  logic [DW-1:0] byte_data_i;
  logic byte_ready_o, byte_ack_o, rx_valid_o, busy_o;
  logic data_evt_o, comp_evt_o, ovf_evt_o, unf_evt_o;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] fill_o;
  logic [SW-1:0] size_o;

  int errs = 0;
  int checks = 0;
  int q[$];

  always #5 clk = ~clk;

  rx_hold_ctrl #(.DEPTH(DEPTH), .DATA_W(DW), .SIZE_W(SW)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int n);
    size_load_i = 1'b1;
    size_val_i  = SW'(n);
    tick();
    size_load_i = 1'b0;
    chk("R3 load", int'(size_o), n);
  endtask

  task automatic start();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic push(input int d, input int exp_ack, input int exp_size);
    bit was_full;
    was_full     = (q.size() == DEPTH);
    byte_valid_i = 1'b1;
    byte_data_i  = DW'(d);
    #1;
    chk("R7 ready", int'(byte_ready_o), 1);
    chk("R4 ack", int'(byte_ack_o), exp_ack);
    tick();
    byte_valid_i = 1'b0;
    if (!was_full) q.push_back(d);
    chk("R3 size", int'(size_o), exp_size);
    chk("R8 ovf", int'(ovf_evt_o), int'(was_full && hold_i == 1'b0));
  endtask

  task automatic pop();
    int e;
    e = q.pop_front();
    #1;
    chk("R2 valid", int'(rx_valid_o), 1);
    chk("R2 data", int'(rd_data_o), e);
    rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
  endtask

  task automatic finish_read(input bit held);
    chk("R5 no early comp", int'(comp_evt_o), 0);
    tick();
    chk("R5 comp", int'(comp_evt_o), 1);
    chk("R5 busy", int'(busy_o), int'(held));
    tick();
    chk("R5 comp pulse", int'(comp_evt_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start_i = 0; size_load_i = 0; hold_i = 0; fifo_clr_i = 0;
    byte_valid_i = 0; rd_en_i = 0; size_val_i = '0; byte_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 ready", int'(byte_ready_o), 0);
    chk("R1 fill", int'(fill_o), 0);
    chk("R1 size", int'(size_o), 0);
    chk("R1 events", int'({data_evt_o, comp_evt_o, ovf_evt_o, unf_evt_o}), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 valid", int'(rx_valid_o), 0);

    // R12: bytes offered while idle are refused
    byte_valid_i = 1'b1;
    byte_data_i  = 8'hA5;
    #1;
    chk("R12 idle ready", int'(byte_ready_o), 0);
    tick();
    byte_valid_i = 1'b0;
    chk("R12 idle fill", int'(fill_o), 0);

    // sweep all counts that fit the FIFO, no hold
    for (int n = 1; n <= DEPTH; n++) begin
      load(n);
      start();
      chk("R5 busy run", int'(busy_o), 1);
      for (int i = 0; i < n; i++) begin
        push(n * 16 + i, int'(i != n - 1), n - 1 - i);
        chk("R6 data evt", int'(data_evt_o), int'(i + 1 == TH));
      end
      #1;
      chk("R12 zero ready", int'(byte_ready_o), 0);
      finish_read(1'b0);
      chk("R2 fill", int'(fill_o), n);
      for (int i = 0; i < n; i++) pop();
      chk("R2 empty", int'(rx_valid_o), 0);
    end

    // R8 overflow without hold
    load(DEPTH + 2);
    start();
    for (int i = 0; i < DEPTH + 2; i++)
      push(8'h40 + i, int'(i != DEPTH + 1), DEPTH + 1 - i);
    finish_read(1'b0);
    chk("R8 fill", int'(fill_o), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop();

    // R9 underflow
    rd_en_i = 1'b1;
    #1;
    chk("R9 zero data", int'(rd_data_o), 0);
    tick();
    rd_en_i = 1'b0;
    chk("R9 unf evt", int'(unf_evt_o), 1);
    chk("R9 fill", int'(fill_o), 0);

    // R7 stretching with hold, R5 held completion
    hold_i = 1'b1;
    load(DEPTH + 2);
    start();
    for (int i = 0; i < DEPTH; i++)
      push(8'h80 + i, 1, DEPTH + 1 - i);
    byte_valid_i = 1'b1;
    byte_data_i  = 8'h8F;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 stall", int'(byte_ready_o), 0);
      tick();
    end
    chk("R7 stall fill", int'(fill_o), DEPTH);
    chk("R7 stall size", int'(size_o), 2);
    byte_valid_i = 1'b0;
    pop();
    push(8'h8F, 1, 1);
    pop();
    push(8'h90, 0, 0);
    finish_read(1'b1);
    hold_i = 1'b0;
    tick();
    chk("R5 hold release", int'(busy_o), 0);
    while (q.size() > 0) pop();

    // R10 reload during a read
    load(5);
    start();
    push(8'h11, 1, 4);
    push(8'h12, 1, 3);
    load(1);
    chk("R10 reload", int'(size_o), 1);
    push(8'h13, 0, 0);
    finish_read(1'b0);
    while (q.size() > 0) pop();

    // R11 clear
    load(3);
    start();
    for (int i = 0; i < 3; i++) push(8'h20 + i, int'(i != 2), 2 - i);
    finish_read(1'b0);
    fifo_clr_i = 1'b1;
    tick();
    fifo_clr_i = 1'b0;
    q.delete();
    chk("R11 fill", int'(fill_o), 0);
    chk("R11 valid", int'(rx_valid_o), 0);

    finish_run();
  end
endmodule